// File: doc/BRIEF.md
# Paged NVRAM Access Bridge

This bridge lets a host reach a 0x2000-byte non-volatile store through one of two device attachment styles. In the paged style the device holds a page-select register and a 32-byte window. Each host request becomes two device cycles. The first loads the page register with the request address shifted right by 5. The second performs the byte read or write inside the window, at the low five address bits multiplied by 16. In the direct style the device is flat: the 13-bit address is multiplied by a static stride, and no page register is touched.

The host side is a request/acknowledge port. A request is taken when `req_valid` and `host_ready` are both high. The bridge then holds `host_ready` low and ignores further requests until it returns a one-cycle `host_ack`, which carries the read data for a read. Each device cycle holds its strobe, address and write data steady until the device raises `dev_done`.

The sequencer has four states. IDLE is the resting state. PAGE drives the page-register write. WIN drives the window or flat access. ACK raises the host acknowledge. The transitions are: IDLE to PAGE when a paged request is accepted, IDLE to WIN when a direct request is accepted, PAGE to WIN on `dev_done`, WIN to ACK on `dev_done`, and ACK to IDLE unconditionally.

Top module: `nvwin_bridge`

## Requirements
- R1: During and after reset, with no request, `host_ready` is 1 and `host_ack`, `dev_wr` and `dev_rd` are 0.
- R2: A request accepted with `map_direct`=0 first produces a device write with `dev_page_sel`=1, `dev_addr`=0 and `dev_wdata` equal to the address bits 12..5 (address shifted right by 5).
- R3: In paged mode the window access has `dev_page_sel`=0 and `dev_addr` = address bits 4..0 shifted left by 4 (0..0x1F0). It starts in the cycle right after the page write's `dev_done` and never before it.
- R4: A request accepted with `map_direct`=1 produces a single device access with `dev_page_sel`=0, `dev_addr` = the 13-bit address times `stride`, and no page-register write.
- R5: `dev_wr` and `dev_rd` are never high together. A strobe, with its address and select, stays high and unchanged until the cycle in which `dev_done` is sampled high, and it is dropped after that cycle.
- R6: `host_ack` is high for exactly one cycle, the cycle after the final device access's `dev_done`. For a read, `host_rdata` in that cycle equals the `dev_rdata` returned with that `dev_done`.
- R7: `host_ready` is low from the cycle after acceptance through the `host_ack` cycle. Requests presented meanwhile create no device access and no acknowledge.
- R8: The mapping style is sampled at acceptance. Changing `map_direct` during a transaction does not alter its device accesses.
- R9: For a write request the window or flat access uses `dev_wr` with `dev_wdata` = `req_wdata`. For a read request it uses `dev_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_direct | input | 1 | 0 = paged window, 1 = flat with stride |
| stride | input | 4 | Static flat-mode address multiplier |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Linear byte address |
| req_wdata | input | 8 | Host write byte |
| host_ready | output | 1 | Bridge idle, request can be taken |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 8 | Read byte, valid with host_ack |
| dev_page_sel | output | 1 | Current device access targets the page register |
| dev_addr | output | 17 | Device byte address |
| dev_wdata | output | 8 | Device write byte |
| dev_wr | output | 1 | Device write strobe |
| dev_rd | output | 1 | Device read strobe |
| dev_done | input | 1 | Device completes the current strobe |
| dev_rdata | input | 8 | Device read byte, valid with dev_done |

## Verification
A sequencer stuck in or skipping a state shows at once at the device bus. A skipped page write makes the window strobe appear without the preceding page access. A stuck state leaves a strobe high after `dev_done`, or delays the acknowledge past the cycle after the last completion. All of these are visible within one or two cycles of the faulty transition. Corrupted captured request fields, such as the wrong page value, offset scaling, stride product or latched mode, show in the `dev_addr`/`dev_wdata` of the very access that uses them. A wrong read capture shows in `host_rdata` on the acknowledge cycle, and data written through one page and read through another exposes page aliasing.

// File: rtl/nvwin_pkg.sv
package nvwin_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PAGE = 2'd1,
        ST_WIN  = 2'd2,
        ST_ACK  = 2'd3
    } nvwin_state_e;

endpackage

// File: rtl/nvwin_addr_map.sv
module nvwin_addr_map #(
    parameter int ADDR_W   = 13,
    parameter int WIN_BITS = 5,
    parameter int SPREAD   = 4,
    parameter int STRIDE_W = 4,
    parameter int DATA_W   = 8,
    parameter int DEV_AW   = ADDR_W + STRIDE_W
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic [STRIDE_W-1:0] stride,
    input  logic                direct,
    output logic [DATA_W-1:0]   page_val,
    output logic [DEV_AW-1:0]   data_addr
);
    localparam int PAGE_W = ADDR_W - WIN_BITS;

    logic [DEV_AW-1:0] win_addr;
    logic [DEV_AW-1:0] flat_addr;

    // page register value: upper address bits, fitted to the data bus
    generate
        if (DATA_W >= PAGE_W) begin : g_page_ext
            assign page_val = DATA_W'(addr[ADDR_W-1:WIN_BITS]);
        end else begin : g_page_trunc
            assign page_val = addr[WIN_BITS +: DATA_W];
        end
    endgenerate

    assign win_addr  = DEV_AW'(addr[WIN_BITS-1:0]) << SPREAD;
    assign flat_addr = DEV_AW'(addr) * DEV_AW'(stride);
    assign data_addr = direct ? flat_addr : win_addr;

endmodule

// File: rtl/nvwin_seq.sv
module nvwin_seq
    import nvwin_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic direct,
    input  logic dev_done,
    output logic idle,
    output logic page_phase,
    output logic win_phase,
    output logic ack_phase
);
    nvwin_state_e state, state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (start)    state_nxt = direct ? ST_WIN : ST_PAGE;
            ST_PAGE: if (dev_done) state_nxt = ST_WIN;
            ST_WIN:  if (dev_done) state_nxt = ST_ACK;
            ST_ACK:                state_nxt = ST_IDLE;
            default:               state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        idle       = 1'b0;
        page_phase = 1'b0;
        win_phase  = 1'b0;
        ack_phase  = 1'b0;
        unique case (state)
            ST_IDLE: idle       = 1'b1;
            ST_PAGE: page_phase = 1'b1;
            ST_WIN:  win_phase  = 1'b1;
            ST_ACK:  ack_phase  = 1'b1;
            default: idle       = 1'b1;
        endcase
    end

endmodule

// File: rtl/nvwin_req_hold.sv
module nvwin_req_hold #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              in_write,
    input  logic              in_direct,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    input  logic              grab_rd,
    input  logic [DATA_W-1:0] rd_byte,
    output logic              q_write,
    output logic              q_direct,
    output logic [ADDR_W-1:0] q_addr,
    output logic [DATA_W-1:0] q_wdata,
    output logic [DATA_W-1:0] q_rdata
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_write  <= 1'b0;
            q_direct <= 1'b0;
            q_addr   <= '0;
            q_wdata  <= '0;
        end else if (take) begin
            q_write  <= in_write;
            q_direct <= in_direct;
            q_addr   <= in_addr;
            q_wdata  <= in_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       q_rdata <= '0;
        else if (grab_rd) q_rdata <= rd_byte;
    end

endmodule

// File: rtl/nvwin_bridge.sv
module nvwin_bridge #(
    parameter int ADDR_W   = 13,
    parameter int WIN_BITS = 5,
    parameter int SPREAD   = 4,
    parameter int STRIDE_W = 4,
    parameter int DATA_W   = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         map_direct,
    input  logic [STRIDE_W-1:0]          stride,
    input  logic                         req_valid,
    input  logic                         req_write,
    input  logic [ADDR_W-1:0]            req_addr,
    input  logic [DATA_W-1:0]            req_wdata,
    output logic                         host_ready,
    output logic                         host_ack,
    output logic [DATA_W-1:0]            host_rdata,
    output logic                         dev_page_sel,
    output logic [ADDR_W+STRIDE_W-1:0]   dev_addr,
    output logic [DATA_W-1:0]            dev_wdata,
    output logic                         dev_wr,
    output logic                         dev_rd,
    input  logic                         dev_done,
    input  logic [DATA_W-1:0]            dev_rdata
);
    localparam int DEV_AW = ADDR_W + STRIDE_W;

    logic              idle, page_phase, win_phase, ack_phase;
    logic              start;
    logic              q_write, q_direct;
    logic [ADDR_W-1:0] q_addr;
    logic [DATA_W-1:0] q_wdata;
    logic [DATA_W-1:0] page_val;
    logic [DEV_AW-1:0] data_addr;
    logic              grab_rd;

    assign start   = req_valid & idle;
    assign grab_rd = win_phase & dev_done & ~q_write;

    nvwin_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .direct     (map_direct),
        .dev_done   (dev_done),
        .idle       (idle),
        .page_phase (page_phase),
        .win_phase  (win_phase),
        .ack_phase  (ack_phase)
    );

    nvwin_req_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (start),
        .in_write  (req_write),
        .in_direct (map_direct),
        .in_addr   (req_addr),
        .in_wdata  (req_wdata),
        .grab_rd   (grab_rd),
        .rd_byte   (dev_rdata),
        .q_write   (q_write),
        .q_direct  (q_direct),
        .q_addr    (q_addr),
        .q_wdata   (q_wdata),
        .q_rdata   (host_rdata)
    );

    nvwin_addr_map #(
        .ADDR_W   (ADDR_W),
        .WIN_BITS (WIN_BITS),
        .SPREAD   (SPREAD),
        .STRIDE_W (STRIDE_W),
        .DATA_W   (DATA_W),
        .DEV_AW   (DEV_AW)
    ) u_map (
        .addr      (q_addr),
        .stride    (stride),
        .direct    (q_direct),
        .page_val  (page_val),
        .data_addr (data_addr)
    );

    always_comb begin
        host_ready   = idle;
        host_ack     = ack_phase;
        dev_page_sel = page_phase;
        dev_addr     = page_phase ? '0 : data_addr;
        dev_wdata    = page_phase ? page_val : q_wdata;
        dev_wr       = page_phase | (win_phase & q_write);
        dev_rd       = win_phase & ~q_write;
    end

endmodule

// File: rtl/nvwin_bridge_chk.sv
module nvwin_bridge_chk #(
    parameter int DEV_AW = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              host_ready,
    input logic              host_ack,
    input logic              dev_wr,
    input logic              dev_rd,
    input logic              dev_page_sel,
    input logic [DEV_AW-1:0] dev_addr,
    input logic              dev_done
);
    a_r5_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(dev_wr && dev_rd));

    a_r5_strobe_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((dev_wr || dev_rd) && !dev_done) |=>
            ((dev_wr || dev_rd) && $stable(dev_addr) && $stable(dev_page_sel)));

    a_r2_page_access: assert property (@(posedge clk) disable iff (!rst_n)
        dev_page_sel |-> (dev_wr && !dev_rd && dev_addr == '0));

    a_r3_window_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_wr && dev_page_sel && dev_done) |=> (!dev_page_sel && (dev_wr || dev_rd)));

    a_r6_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack);

    a_r6_ack_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |-> $past((dev_wr || dev_rd) && dev_done && !dev_page_sel));

    a_r7_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && host_ready) |=> !host_ready);

    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |-> !(dev_wr || dev_rd || host_ack));

endmodule

bind nvwin_bridge nvwin_bridge_chk #(.DEV_AW(ADDR_W + STRIDE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .host_ready   (host_ready),
    .host_ack     (host_ack),
    .dev_wr       (dev_wr),
    .dev_rd       (dev_rd),
    .dev_page_sel (dev_page_sel),
    .dev_addr     (dev_addr),
    .dev_done     (dev_done)
);

// File: tb/nvwin_bridge_tb.sv
module nvwin_bridge_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        map_direct = 1'b0;
    logic [3:0]  stride = 4'd1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [12:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        host_ready, host_ack;
    logic [7:0]  host_rdata;
    logic        dev_page_sel;
    logic [16:0] dev_addr;
    logic [7:0]  dev_wdata;
    logic        dev_wr, dev_rd;
    logic        dev_done = 1'b0;
    logic [7:0]  dev_rdata = '0;

    always #2 clk = ~clk;

    nvwin_bridge u_dut (
        .clk(clk), .rst_n(rst_n), .map_direct(map_direct), .stride(stride),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .host_ready(host_ready), .host_ack(host_ack),
        .host_rdata(host_rdata), .dev_page_sel(dev_page_sel), .dev_addr(dev_addr),
        .dev_wdata(dev_wdata), .dev_wr(dev_wr), .dev_rd(dev_rd),
        .dev_done(dev_done), .dev_rdata(dev_rdata)
    );

    typedef struct packed {
        logic        wr;
        logic        psel;
        logic [16:0] addr;
        logic [7:0]  wdata;
    } dev_op_t;

    typedef struct packed {
        logic       rd;
        logic [7:0] data;
    } rsp_t;

    dev_op_t exp_dev[$];
    rsp_t    exp_rsp[$];
    logic [7:0] ref_mem[int unsigned];
    logic [7:0] dev_mem[int unsigned];

    int checks = 0;
    int errors = 0;
    int dev_lat = 0;
    bit finished = 0;

    function automatic logic [7:0] init_val(int unsigned k);
        return 8'(k ^ (k >> 8) ^ (k >> 17) ^ 32'h3C);
    endfunction

    function automatic int unsigned exp_key(bit direct, logic [12:0] a, logic [3:0] s);
        if (direct) return 32'(a) * 32'(s);
        return (32'd1 << 25) | (32'(a[12:5]) << 17) | (32'(a[4:0]) << 4);
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // device model: answers strobes after dev_lat wait cycles
    initial begin
        int unsigned cnt = 0;
        bit          page_pending = 0;
        logic [7:0]  page = '0;
        forever begin
            @(posedge clk);
            #1;
            if (dev_wr || dev_rd) begin
                if (cnt >= dev_lat) begin
                    int unsigned k;
                    dev_done = 1'b1;
                    cnt = 0;
                    if (dev_page_sel) begin
                        page = dev_wdata;
                        page_pending = 1;
                    end else begin
                        k = page_pending ? ((32'd1 << 25) | (32'(page) << 17) | 32'(dev_addr))
                                         : 32'(dev_addr);
                        page_pending = 0;
                        if (dev_wr) dev_mem[k] = dev_wdata;
                        else dev_rdata = dev_mem.exists(k) ? dev_mem[k] : init_val(k);
                    end
                end else begin
                    dev_done = 1'b0;
                    cnt++;
                end
            end else begin
                dev_done = 1'b0;
                cnt = 0;
            end
        end
    end

    // monitor: compares device accesses and acknowledges against the queues
    initial begin
        int  scnt = 0;
        bit  prev_ack = 0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (dev_wr && dev_rd)
                    check(0, "R5", "both strobes high", 1, 0);
                if (dev_wr || dev_rd) scnt++;
                if ((dev_wr || dev_rd) && dev_done) begin
                    check(scnt == dev_lat + 1, "R5", "strobe length", scnt, dev_lat + 1);
                    scnt = 0;
                    if (exp_dev.size() == 0) begin
                        check(0, "R7", "unexpected device access addr", int'(dev_addr), 0);
                    end else begin
                        dev_op_t e;
                        e = exp_dev.pop_front();
                        check(dev_page_sel == e.psel,
                              e.psel ? "R2" : "R3", "page select", dev_page_sel, e.psel);
                        check(dev_addr == e.addr,
                              e.psel ? "R2" : "R4", "device address", int'(dev_addr), int'(e.addr));
                        check(dev_wr == e.wr, "R9", "write strobe", dev_wr, e.wr);
                        if (e.wr)
                            check(dev_wdata == e.wdata, e.psel ? "R2" : "R9",
                                  "device wdata", dev_wdata, e.wdata);
                    end
                end
                if (host_ack) begin
                    check(!prev_ack, "R6", "ack longer than one cycle", 1, 0);
                    check(!host_ready, "R7", "ready during ack", host_ready, 0);
                    if (exp_rsp.size() == 0) begin
                        check(0, "R7", "unexpected ack", 1, 0);
                    end else begin
                        rsp_t r;
                        r = exp_rsp.pop_front();
                        check(exp_dev.size() == 0, "R6", "ack before device accesses done",
                              exp_dev.size(), 0);
                        if (r.rd)
                            check(host_rdata == r.data, "R6", "read data", host_rdata, r.data);
                    end
                end
                prev_ack = host_ack;
            end
        end
    end

    task automatic access(bit wr, logic [12:0] a, logic [7:0] d,
                          bit poke_busy, bit flip_mode);
        bit direct;
        int unsigned k;
        @(negedge clk);
        direct    = map_direct;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        k = exp_key(direct, a, stride);
        if (!direct)
            exp_dev.push_back('{wr: 1'b1, psel: 1'b1, addr: 17'd0, wdata: a[12:5]});
        exp_dev.push_back('{wr: wr, psel: 1'b0,
                            addr: direct ? 17'(k) : 17'(32'(a[4:0]) << 4), wdata: d});
        if (wr) begin
            ref_mem[k] = d;
            exp_rsp.push_back('{rd: 1'b0, data: 8'h00});
        end else begin
            exp_rsp.push_back('{rd: 1'b1, data: ref_mem.exists(k) ? ref_mem[k] : init_val(k)});
        end
        @(negedge clk);
        check(!host_ready, "R7", "ready after acceptance", host_ready, 0);
        if (poke_busy) begin
            req_addr  = a ^ 13'h0421;
            req_write = ~wr;
        end else begin
            req_valid = 1'b0;
        end
        if (flip_mode) map_direct = ~map_direct;
        while (!host_ack) @(negedge clk);
        req_valid = 1'b0;
        if (flip_mode) map_direct = direct;
        @(negedge clk);
        check(exp_dev.size() == 0 && exp_rsp.size() == 0, poke_busy ? "R7" : "R8",
              "leftover expectations", exp_dev.size() + exp_rsp.size(), 0);
        check(host_ready && !host_ack, "R6", "ready back after ack",
              {host_ready, host_ack}, 2);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [12:0] lfsr = 13'h1ACE;
        repeat (3) @(negedge clk);
        check(host_ready && !host_ack && !dev_wr && !dev_rd, "R1", "outputs in reset",
              {host_ready, host_ack, dev_wr, dev_rd}, 8);
        rst_n = 1'b1;
        @(negedge clk);
        check(host_ready && !host_ack && !dev_wr && !dev_rd, "R1", "outputs after reset",
              {host_ready, host_ack, dev_wr, dev_rd}, 8);

        // paged mode, immediate device
        dev_lat = 0;
        map_direct = 1'b0;
        access(1, 13'h0000, 8'h11, 0, 0);   // R2 R3 R9
        access(0, 13'h0000, 8'h00, 0, 0);
        access(1, 13'h1FFF, 8'hC3, 0, 0);   // R3 boundary page 0xFF, offset 0x1F0
        access(0, 13'h1FFF, 8'h00, 0, 0);
        access(0, 13'h0123, 8'h00, 0, 0);   // unwritten byte
        access(1, 13'h0020, 8'h77, 0, 0);   // other page, same offset
        access(0, 13'h0000, 8'h00, 0, 0);

        // slow device, busy requests ignored (R7), strobes held (R5)
        dev_lat = 3;
        access(1, 13'h0A5F, 8'h5A, 1, 0);
        access(0, 13'h0A5F, 8'h00, 1, 0);

        // mode change mid-transaction (R8)
        dev_lat = 2;
        access(1, 13'h0333, 8'h9E, 0, 1);
        access(0, 13'h0333, 8'h00, 0, 1);

        // direct mode (R4)
        map_direct = 1'b1;
        dev_lat = 0;
        stride = 4'd1;
        access(1, 13'h0005, 8'hE1, 0, 0);
        access(0, 13'h0005, 8'h00, 0, 0);
        stride = 4'd15;
        access(0, 13'h1FFF, 8'h00, 0, 0);   // largest flat address
        access(1, 13'h0100, 8'h42, 0, 1);   // R8 flip into paged must not apply
        access(0, 13'h0100, 8'h00, 0, 0);

        // mixed pattern
        for (int i = 0; i < 24; i++) begin
            lfsr = {lfsr[11:0], lfsr[12] ^ lfsr[3] ^ lfsr[2] ^ lfsr[0]};
            map_direct = lfsr[7];
            stride = lfsr[3:0];
            dev_lat = i % 3;
            access(lfsr[1], lfsr, lfsr[10:3], i[0], 0);
            access(0, lfsr, 8'h00, 0, 0);
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
        $finish;
    end

endmodule